// File: doc/BRIEF.md
# Circular-Region Burst Reader to Stream

This block fetches data from a ring-shaped memory region and passes it on as a stream. It issues fixed 16-beat read bursts of 64-bit words on an AXI4 read address channel. It accepts the returning beats on the read data channel into an internal FIFO. That FIFO drives an AXI4-Stream output. A burst is requested only when the FIFO can take all of its beats. The space is claimed at the moment the address is accepted, so returning data can never overflow the FIFO.

Two runtime inputs set the region: a byte base address and a wrap limit for a burst counter. Each burst covers 128 bytes at base plus counter times 128. The counter advances on every accepted burst and returns to zero after it has reached the limit. A status output shows the counter, so a user can see how far the reader has progressed through the ring. A sticky flag reports read data whose last-beat marker does not match the beat position.

Top module: `mem_stream_reader`

## Requirements
- R1: A read address is presented (arValid high) only while the FIFO entries held plus the entries claimed by an outstanding burst leave room for at least 16 more beats.
- R2: While arValid is high, arLen is 15, arSize is 3 (8-byte beats) and arBurst is 2'b01 (incrementing).
- R3: Each accepted read address equals cfgBase + 128 * statusCount, using the counter value before the acceptance.
- R4: On each accepted read address the counter becomes 0 if it equalled cfgMax and otherwise increments by one; it changes at no other time.
- R5: statusCount shows the current burst counter at all times.
- R6: At most one burst is outstanding. rReady is high exactly from the cycle after the address is accepted until the 16th beat has been taken, and arValid is never high while rReady is high.
- R7: errLast is set when a read beat arrives with rLast differing from "this is the 16th beat of the burst". It then stays set until reset.
- R8: tValid is high exactly when the FIFO holds data. tData is the oldest stored beat, beats leave in arrival order, and tValid and tData hold steady while tReady is low.
- R9: Once raised, arValid stays high with arAddr unchanged until arReady is seen.
- R10: A synchronous active-low reset clears the counter, the claimed space, the FIFO and errLast, and drops arValid, rReady and tValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgBase | input | 32 | Byte base address of the ring |
| cfgMax | input | 16 | Highest burst counter value before wrap |
| statusCount | output | 16 | Current burst counter |
| errLast | output | 1 | Sticky last-beat mismatch flag |
| arAddr | output | 32 | Read burst byte address |
| arLen | output | 8 | Burst length minus one |
| arSize | output | 3 | Beat size code |
| arBurst | output | 2 | Burst type |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rData | input | 64 | Read data beat |
| rLast | input | 1 | Last beat marker from memory |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| tData | output | 64 | Stream data |
| tValid | output | 1 | Stream valid |
| tReady | input | 1 | Stream ready |

## Verification
A read beat entering the FIFO and a stream beat leaving it can occur in the same cycle. A pop can also coincide with the cycle in which the space check decides whether to request the next burst. The bench provokes both by throttling tReady, rValid and arReady with pseudo-random patterns. It also stalls the stream long enough for the FIFO to fill to the edge of a burst. A behavioural queue model updates its contents and its count of claimed space from the same handshakes each cycle. The bench compares every output against that model on every clock, so a miscounted simultaneous push and pop shows up as a mismatch in tValid, tData, or the space rule for arValid.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadAddr;  // capture the next burst address
    logic push;      // write the current read beat into the FIFO
  } msr_strobe_t;
endpackage

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 16,
  parameter int DEPTH      = 32,
  parameter int BYTE_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  msr_strobe_t       strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  burstCnt,
  input  logic [DATA_W-1:0] rData,
  input  logic              tReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [DATA_W-1:0] tData,
  output logic              tValid,
  output logic              popEv
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [OCC_W-1:0]  occ;

  assign tValid = (occ != '0);
  assign popEv  = tValid && tReady;
  assign tData  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= rData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (popEv)       rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, popEv})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) arAddr <= '0;
    else if (strobe.loadAddr)
      arAddr <= cfgBase + (ADDR_W'(burstCnt) << BYTE_SHIFT);
  end
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 32,
  parameter int BURST = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgMax,
  input  logic             arReady,
  input  logic             rValid,
  input  logic             rLast,
  input  logic             popEv,
  output msr_strobe_t      strobe,
  output logic             arValid,
  output logic             rReady,
  output logic [CNT_W-1:0] burstCnt,
  output logic             errLast
);
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int BEAT_W = $clog2(BURST);
  localparam logic [OCC_W-1:0]  RESV_LIM = OCC_W'(DEPTH - BURST);
  localparam logic [OCC_W-1:0]  BURST_OC = OCC_W'(BURST);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST - 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} state_t;

  state_t            state;
  logic [OCC_W-1:0]  resvQ;
  logic [BEAT_W-1:0] beatQ;
  logic              spaceOk, arAcc, beatAcc, lastBeat;

  assign spaceOk  = (resvQ <= RESV_LIM);
  assign arValid  = (state == S_ADDR);
  assign rReady   = (state == S_DATA);
  assign arAcc    = arValid && arReady;
  assign beatAcc  = rReady && rValid;
  assign lastBeat = (beatQ == LAST_IDX);

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = (state == S_IDLE) && spaceOk;
    strobe.push     = beatAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      beatQ    <= '0;
      burstCnt <= '0;
      errLast  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (spaceOk) state <= S_ADDR;
        S_ADDR: if (arReady) begin
          state    <= S_DATA;
          burstCnt <= (burstCnt == cfgMax) ? '0 : burstCnt + 1'b1;
        end
        S_DATA: if (rValid) begin
          beatQ <= lastBeat ? '0 : beatQ + 1'b1;
          if (lastBeat) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (beatAcc && (rLast != lastBeat)) errLast <= 1'b1;
    end
  end

  // claimed space: held entries plus beats still owed by the open burst
  always_ff @(posedge clk) begin
    if (!rstN) resvQ <= '0;
    else case ({arAcc, popEv})
      2'b10:   resvQ <= resvQ + BURST_OC;
      2'b11:   resvQ <= resvQ + BURST_OC - 1'b1;
      2'b01:   resvQ <= resvQ - 1'b1;
      default: resvQ <= resvQ;
    endcase
  end
endmodule

// File: rtl/mem_stream_reader.sv
module mem_stream_reader
  import msr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 32,
  parameter int BURST  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CNT_W-1:0]  cfgMax,
  output logic [CNT_W-1:0]  statusCount,
  output logic              errLast,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  output logic              arValid,
  input  logic              arReady,
  input  logic [DATA_W-1:0] rData,
  input  logic              rLast,
  input  logic              rValid,
  output logic              rReady,
  output logic [DATA_W-1:0] tData,
  output logic              tValid,
  input  logic              tReady
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BYTE_SHIFT = $clog2(BURST * BEAT_BYTES);

  msr_strobe_t      strobe;
  logic             popEv;
  logic [CNT_W-1:0] burstCnt;

  assign arLen       = 8'(BURST - 1);
  assign arSize      = 3'($clog2(BEAT_BYTES));
  assign arBurst     = 2'b01;
  assign statusCount = burstCnt;

  msr_ctrl #(.CNT_W(CNT_W), .DEPTH(DEPTH), .BURST(BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMax(cfgMax), .arReady(arReady),
    .rValid(rValid), .rLast(rLast), .popEv(popEv), .strobe(strobe),
    .arValid(arValid), .rReady(rReady), .burstCnt(burstCnt), .errLast(errLast)
  );

  msr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                 .DEPTH(DEPTH), .BYTE_SHIFT(BYTE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase),
    .burstCnt(burstCnt), .rData(rData), .tReady(tReady), .arAddr(arAddr),
    .tData(tData), .tValid(tValid), .popEv(popEv)
  );
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 32,
  parameter int BURST  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [CNT_W-1:0]  cfgMax,
  input logic [CNT_W-1:0]  statusCount,
  input logic              errLast,
  input logic [ADDR_W-1:0] arAddr,
  input logic [7:0]        arLen,
  input logic [2:0]        arSize,
  input logic [1:0]        arBurst,
  input logic              arValid,
  input logic              arReady,
  input logic              rValid,
  input logic              rReady,
  input logic [DATA_W-1:0] tData,
  input logic              tValid,
  input logic              tReady
);
  int held, owed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= 0;
      owed <= 0;
    end else begin
      held <= held + ((rValid && rReady) ? 1 : 0) - ((tValid && tReady) ? 1 : 0);
      if (arValid && arReady)  owed <= BURST;
      else if (rValid && rReady) owed <= owed - 1;
    end
  end

  p_space_r1: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (held + owed) <= (DEPTH - BURST));

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    held <= DEPTH);

  p_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (arLen == 8'(BURST - 1)) && (arSize == 3'd3) && (arBurst == 2'b01));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && arReady) |=> statusCount ==
      (($past(statusCount) == $past(cfgMax)) ? '0 : $past(statusCount) + 1'b1));

  p_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && arReady) |=> $stable(statusCount));

  p_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> !rReady);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errLast |=> errLast);

  p_hold_stream_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tValid && !tReady) |=> tValid && $stable(tData));

  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> arValid && $stable(arAddr));
endmodule

bind mem_stream_reader msr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .BURST(BURST)
) u_msr_checker (.*);

// File: tb/mem_stream_reader_bench.sv
module mem_stream_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgBase = 32'h4000_0000;
  logic [15:0] cfgMax = 16'd3;
  logic [15:0] statusCount;
  logic        errLast;
  logic [31:0] arAddr;
  logic [7:0]  arLen;
  logic [2:0]  arSize;
  logic [1:0]  arBurst;
  logic        arValid;
  logic        arReady = 1'b0;
  logic [63:0] rData = '0;
  logic        rLast = 1'b0;
  logic        rValid = 1'b0;
  logic        rReady;
  logic [63:0] tData;
  logic        tValid;
  logic        tReady = 1'b0;

  mem_stream_reader u_mem_stream_reader (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  // 0 = always high, 1 = pseudo-random, 2 = always low
  int          arMode = 0, rMode = 0, tMode = 0;
  bit          injectErr = 0;
  int          nChecks = 0, nFail = 0, nBursts = 0, cyc = 0;
  bit          done = 0, postReset = 1, prevArWait = 0;
  logic [31:0] prevAddr = '0;
  logic [31:0] lfsr = 32'hACE1_2467;
  logic [15:0] mCnt = '0;
  bit          mErr = 0;
  logic [63:0] fifoQ[$];
  logic [63:0] pendQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] memWord(input logic [31:0] addr, input int beat);
    return {addr + 32'(beat * 8), 32'hC0DE_0000 | 32'(beat)};
  endfunction

  function automatic bit pick(input int mode, input bit rnd);
    return (mode == 0) ? 1'b1 : (mode == 1) ? rnd : 1'b0;
  endfunction

  always @(negedge clk) begin
    bit pop, push, acc;
    cyc++;
    // compare outputs with the model
    chk(statusCount == mCnt, postReset ? "R10" : "R5", "statusCount", 64'(statusCount), 64'(mCnt));
    chk(errLast == mErr, postReset ? "R10" : "R7", "errLast", 64'(errLast), 64'(mErr));
    chk(tValid == (fifoQ.size() != 0), postReset ? "R10" : "R8", "tValid",
        64'(tValid), 64'(fifoQ.size() != 0));
    if (tValid && fifoQ.size() != 0)
      chk(tData == fifoQ[0], "R8", "tData order", tData, fifoQ[0]);
    chk(rReady == (pendQ.size() != 0), postReset ? "R10" : "R6", "rReady",
        64'(rReady), 64'(pendQ.size() != 0));
    if (arValid) begin
      chk(pendQ.size() == 0, "R6", "arValid with burst open", 64'(pendQ.size()), 64'd0);
      chk(DEPTH - fifoQ.size() >= 16, "R1", "free space at request",
          64'(DEPTH - fifoQ.size()), 64'd16);
      chk(arLen == 8'd15 && arSize == 3'd3 && arBurst == 2'b01, "R2", "burst fields",
          {51'd0, arLen, arSize, arBurst}, {51'd0, 8'd15, 3'd3, 2'b01});
    end
    if (prevArWait) begin
      chk(arValid == 1'b1, "R9", "arValid held", 64'(arValid), 64'd1);
      chk(arAddr == prevAddr, "R9", "arAddr held", 64'(arAddr), 64'(prevAddr));
    end
    postReset = 0;

    // drive inputs for the coming edge
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    arReady = pick(arMode, lfsr[3]);
    tReady  = pick(tMode, lfsr[7] | lfsr[12]);
    if (pendQ.size() != 0 && pick(rMode, lfsr[17] | lfsr[5])) begin
      rValid = 1'b1;
      rData  = pendQ[0];
      rLast  = (pendQ.size() == 1) ^ (injectErr && pendQ.size() == 5);
    end else begin
      rValid = 1'b0;
      rData  = '0;
      rLast  = 1'b0;
    end

    // advance the model to the state after the coming edge
    if (!rstN) begin
      fifoQ.delete();
      pendQ.delete();
      mCnt = '0;
      mErr = 0;
      postReset = 1;
      prevArWait = 0;
    end else begin
      pop  = tValid && tReady;
      push = rValid && rReady;
      acc  = arValid && arReady;
      if (pop && fifoQ.size() != 0) void'(fifoQ.pop_front());
      if (push && pendQ.size() != 0) begin
        if (rLast != (pendQ.size() == 1)) begin
          mErr = 1;
          injectErr = 0;
        end
        fifoQ.push_back(pendQ.pop_front());
      end
      if (acc) begin
        chk(arAddr == cfgBase + {9'd0, mCnt, 7'd0}, "R3", "burst address",
            64'(arAddr), 64'(cfgBase + {9'd0, mCnt, 7'd0}));
        for (int b = 0; b < 16; b++) pendQ.push_back(memWord(arAddr, b));
        mCnt = (mCnt == cfgMax) ? '0 : mCnt + 16'd1;  // R4 wrap rule
        nBursts++;
      end
      prevArWait = arValid && !arReady;
      prevAddr   = arAddr;
    end

    if (cyc > WATCHDOG && !done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic waitBursts(input int n);
    int target = nBursts + n;
    while (nBursts < target) @(posedge clk);
    #1;
  endtask

  initial begin
    // R10: reset state observed at the first negedges
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R3/R4: full-speed run, ring of four bursts wrapping several times
    waitBursts(10);
    // R1/R8: throttled handshakes on every channel
    arMode = 1; rMode = 1; tMode = 1;
    cfgMax = 16'd5;
    waitBursts(8);
    // R4 with a zero limit and a new base, changed while no address is pending
    do begin @(posedge clk); #1; end while (arValid || statusCount != 16'd0);
    cfgMax  = 16'd0;
    cfgBase = 32'h0008_0000;
    waitBursts(6);
    // R1/R8: stall the stream until the FIFO is filled as far as space allows
    tMode = 2;
    repeat (300) @(posedge clk);
    #1 tMode = 1;
    waitBursts(4);
    // R7: early last marker inside one burst
    injectErr = 1;
    waitBursts(3);
    // R10: reset in the middle of a burst
    do begin @(posedge clk); #1; end while (!rReady);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    cfgMax  = 16'd2;
    cfgBase = 32'h1230_0000;
    arMode = 0; rMode = 1; tMode = 1;
    waitBursts(7);
    repeat (40) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule